// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control half of a small accumulator machine. It keeps a control address register, reads a horizontal control word from a combinational microcode store at that address, and drives the word to the datapath. Each bit of the word is one register-transfer enable, covering the memory address and buffer registers, the instruction and program-counter registers, the operand, accumulator and multiply-result registers, memory read/write and ALU strobes. Four of the bits choose the next control address.

Every instruction starts with a shared three-word fetch routine. The last fetch word loads the control address from the opcode map, which is the opcode shifted left by three. Each routine therefore owns eight microwords. The datapath supplies the high byte of the memory buffer as the opcode. It also supplies a flag, the accumulator sign bit, which the conditional jump uses to skip one microword. Each routine ends by clearing the control address back to fetch. The HALT routine freezes the sequencer until reset.

Top module: `ucode_ctrl_unit`

## Requirements
- R1: After a synchronous active-low reset, car_o is 0x00, halted_o is 0 and ctrl_o is the first fetch word, 0x000021.
- R2: Control word bit positions are: 0 advance, 1 opcode map, 2 return to zero, 3 buffer from memory, 4 memory write, 5 address from PC, 6 address from buffer low byte, 7 instruction load, 8 PC increment, 9 operand register load, 10 accumulator clear, 11 accumulator from buffer, 12 buffer from accumulator, 13 accumulator from ALU, 14 ALU A from accumulator, 15 ALU compute, 16 ALU multiply, 17 multiply-result load, 18 buffer from multiply-result, 19 PC from buffer low byte, 20 ALU B from operand register, 21 flag skip.
- R3: When bit 0 is the active next-address bit, the control address increments by one at the next clock.
- R4: When bit 1 is set, the next control address is the opcode input shifted left by three, keeping the low 8 bits. This happens in the same cycle in which the instruction register loads, so opcode 0x20 wraps to 0x00.
- R5: When bit 2 is set outside HALT, the next control address is 0x00.
- R6: When bit 21 is set, the next address is the current address plus one plus flag. With the flag low the sequencer goes to 0x21, and with it high it goes to 0x22.
- R7: The fetch words at 0x00, 0x01 and 0x02 are 0x000021, 0x000009 and 0x000082.
- R8: Opcodes 1 to 8 (store, load, add, conditional jump, jump, halt, multiply, store multiply-result) start at 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38 and 0x40.
- R9: Load runs 0x141, 0x009, 0x601, 0x104001, 0x8001 and 0x2004. Add runs 0x141, 0x009, 0x201, 0x104001, 0x8001 and 0x2004. Multiply runs 0x141, 0x009, 0x201, 0x104001, 0x10001 and 0x22004.
- R10: Store runs 0x141, 0x1001 and 0x14. Store multiply-result runs 0x141, 0x40001 and 0x14.
- R11: Word 0x20 is 0x200000, words 0x21 and 0x28 are 0x80004, and word 0x22 is 0x104.
- R12: At 0x30 ctrl_o shows 0x4. From the next clock on, halted_o is 1, car_o stays at 0x30 and ctrl_o is 0, whatever the opcode and flag inputs do, until reset.
- R13: Every microaddress not listed above holds 0x000004, so an unassigned opcode such as 9 returns to fetch after one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | 8 | High byte of the memory buffer register |
| flag_i | input | 1 | Accumulator sign, used by the flag skip |
| ctrl_o | output | 22 | Current control word |
| car_o | output | 8 | Current control address |
| halted_o | output | 1 | Sequencer stopped by HALT |

## Verification
The bench builds the block with its default parameters: an 8-bit control address, an 8-bit opcode and a routine stride of eight words. These values let it walk every assigned routine word by word through fetch and back. They also put in reach the one place where the opcode shift overflows the control address (opcode 0x20 wrapping to fetch) and an unassigned routine slot. Both flag values of the conditional jump are driven, and the opcode and flag inputs are disturbed while halted.

// File: rtl/ucu_pkg.sv
// Shared definitions for the microprogrammed control sequencer.
// Assumes a fixed 22-bit horizontal control word, one bit per enable.
package ucu_pkg;
    localparam int CW_W = 22;

    // Control word bit positions
    localparam int B_INC        = 0;
    localparam int B_MAP        = 1;
    localparam int B_CLR        = 2;
    localparam int B_MBR_MEM    = 3;
    localparam int B_MEM_WR     = 4;
    localparam int B_MAR_PC     = 5;
    localparam int B_MAR_MBR    = 6;
    localparam int B_IR_LD      = 7;
    localparam int B_PC_INC     = 8;
    localparam int B_BR_LD      = 9;
    localparam int B_ACC_CLR    = 10;
    localparam int B_ACC_MBR    = 11;
    localparam int B_MBR_ACC    = 12;
    localparam int B_ACC_ALU    = 13;
    localparam int B_ALU_A_ACC  = 14;
    localparam int B_ALU_CALC   = 15;
    localparam int B_ALU_MUL    = 16;
    localparam int B_MR_LD      = 17;
    localparam int B_MBR_MR     = 18;
    localparam int B_PC_MBR     = 19;
    localparam int B_ALU_B_BR   = 20;
    localparam int B_INC_FLAG   = 21;

    typedef logic [CW_W-1:0] cword_t;

    // Build a control word from a list of enable positions
    function automatic cword_t cw(input int unsigned a, input int unsigned b = 99,
                                 input int unsigned c = 99);
        cword_t w;
        w = '0;
        w[a] = 1'b1;
        if (b < CW_W) w[b] = 1'b1;
        if (c < CW_W) w[c] = 1'b1;
        return w;
    endfunction

    // Named microwords
    localparam cword_t W_FETCH_MAR  = cw(B_INC, B_MAR_PC);
    localparam cword_t W_READ       = cw(B_INC, B_MBR_MEM);
    localparam cword_t W_DECODE     = cw(B_MAP, B_IR_LD);
    localparam cword_t W_OPERAND    = cw(B_INC, B_PC_INC, B_MAR_MBR);
    localparam cword_t W_BUF_ACC    = cw(B_INC, B_MBR_ACC);
    localparam cword_t W_WRITE_BACK = cw(B_CLR, B_MEM_WR);
    localparam cword_t W_CLR_BR     = cw(B_INC, B_ACC_CLR, B_BR_LD);
    localparam cword_t W_BR         = cw(B_INC, B_BR_LD);
    localparam cword_t W_ALU_IN     = cw(B_INC, B_ALU_A_ACC, B_ALU_B_BR);
    localparam cword_t W_ALU_CALC   = cw(B_INC, B_ALU_CALC);
    localparam cword_t W_ACC_RES    = cw(B_CLR, B_ACC_ALU);
    localparam cword_t W_ALU_MUL    = cw(B_INC, B_ALU_MUL);
    localparam cword_t W_MUL_RES    = cw(B_CLR, B_ACC_ALU, B_MR_LD);
    localparam cword_t W_BUF_MR     = cw(B_INC, B_MBR_MR);
    localparam cword_t W_SKIP       = cw(B_INC_FLAG);
    localparam cword_t W_JUMP       = cw(B_CLR, B_PC_MBR);
    localparam cword_t W_NEXT_PC    = cw(B_CLR, B_PC_INC);
    localparam cword_t W_RETURN     = cw(B_CLR);
endpackage

// File: rtl/ucu_opcode_map.sv
// Opcode to routine start address.
// Each routine owns 2**SHIFT words. The result is truncated or
// zero-extended to the control address width.
module ucu_opcode_map #(
    parameter int OP_W  = 8,
    parameter int CAR_W = 8,
    parameter int SHIFT = 3
) (
    input  logic [OP_W-1:0]  opcode_i,
    output logic [CAR_W-1:0] start_o
);
    localparam int WIDE_W = OP_W + SHIFT;

    logic [WIDE_W-1:0] wide;

    // Scale the opcode by the routine stride
    always_comb wide = {opcode_i, {SHIFT{1'b0}}};

    generate
        if (CAR_W <= WIDE_W) begin : g_trunc
            // Keep the low bits; high opcodes wrap
            always_comb start_o = wide[CAR_W-1:0];
        end else begin : g_ext
            // Pad with zeros when the address is wider
            always_comb start_o = {{(CAR_W-WIDE_W){1'b0}}, wide};
        end
    endgenerate
endmodule

// File: rtl/ucu_ctrl_store.sv
// Combinational microcode store.
// Returns the control word at the given address. Unassigned addresses
// hold a bare return-to-fetch word. Assumes the default stride of eight.
module ucu_ctrl_store
    import ucu_pkg::*;
#(
    parameter int CAR_W = 8
) (
    input  logic [CAR_W-1:0] addr_i,
    output cword_t           word_o
);
    // Address lookup of the microprogram
    always_comb begin
        case (int'(addr_i))
            'h00: word_o = W_FETCH_MAR;
            'h01: word_o = W_READ;
            'h02: word_o = W_DECODE;
            // store accumulator
            'h08: word_o = W_OPERAND;
            'h09: word_o = W_BUF_ACC;
            'h0A: word_o = W_WRITE_BACK;
            // load
            'h10: word_o = W_OPERAND;
            'h11: word_o = W_READ;
            'h12: word_o = W_CLR_BR;
            'h13: word_o = W_ALU_IN;
            'h14: word_o = W_ALU_CALC;
            'h15: word_o = W_ACC_RES;
            // add
            'h18: word_o = W_OPERAND;
            'h19: word_o = W_READ;
            'h1A: word_o = W_BR;
            'h1B: word_o = W_ALU_IN;
            'h1C: word_o = W_ALU_CALC;
            'h1D: word_o = W_ACC_RES;
            // conditional jump
            'h20: word_o = W_SKIP;
            'h21: word_o = W_JUMP;
            'h22: word_o = W_NEXT_PC;
            // jump
            'h28: word_o = W_JUMP;
            // halt
            'h30: word_o = W_RETURN;
            // multiply
            'h38: word_o = W_OPERAND;
            'h39: word_o = W_READ;
            'h3A: word_o = W_BR;
            'h3B: word_o = W_ALU_IN;
            'h3C: word_o = W_ALU_MUL;
            'h3D: word_o = W_MUL_RES;
            // store multiply result
            'h40: word_o = W_OPERAND;
            'h41: word_o = W_BUF_MR;
            'h42: word_o = W_WRITE_BACK;
            default: word_o = W_RETURN;
        endcase
    end
endmodule

// File: rtl/ucu_sequencer.sv
// Control address register, next-address selection and halt latch.
// Assumes at most one next-address bit per word. Priority is map,
// then clear, then flag skip, then advance; with none set the address holds.
module ucu_sequencer
    import ucu_pkg::*;
#(
    parameter int CAR_W = 8,
    parameter logic [CAR_W-1:0] HALT_ADDR = 8'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cword_t           word_i,
    input  logic [CAR_W-1:0] map_addr_i,
    input  logic             flag_i,
    output logic [CAR_W-1:0] car_o,
    output logic             halted_o
);
    localparam logic [CAR_W-1:0] ONE = CAR_W'(1);

    logic [CAR_W-1:0] car_q;
    logic [CAR_W-1:0] car_next;
    logic             halted_q;
    logic             at_halt;

    // Detect the halt microaddress
    always_comb at_halt = (car_q == HALT_ADDR);

    // Select the next control address
    always_comb begin
        car_next = car_q;
        if (word_i[B_MAP])
            car_next = map_addr_i;
        else if (word_i[B_CLR])
            car_next = '0;
        else if (word_i[B_INC_FLAG])
            car_next = car_q + ONE + {{(CAR_W-1){1'b0}}, flag_i};
        else if (word_i[B_INC])
            car_next = car_q + ONE;
    end

    // Advance the address or latch the halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q    <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            if (at_halt)
                halted_q <= 1'b1;
            else
                car_q <= car_next;
        end
    end

    always_comb car_o    = car_q;
    always_comb halted_o = halted_q;

    p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !at_halt && word_i[B_INC] && !word_i[B_MAP] && !word_i[B_CLR]
         && !word_i[B_INC_FLAG]) |=> (car_q == $past(car_q) + ONE));

    p_map_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !at_halt && word_i[B_MAP]) |=> (car_q == $past(map_addr_i)));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !at_halt && word_i[B_CLR] && !word_i[B_MAP]) |=> (car_q == '0));

    p_flag_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !at_halt && word_i[B_INC_FLAG] && !word_i[B_MAP] && !word_i[B_CLR])
        |=> (car_q == $past(car_q) + ONE + {{(CAR_W-1){1'b0}}, $past(flag_i)}));

    p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> (halted_q && $stable(car_q)));

    p_halt_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && at_halt) |=> (halted_q && car_q == HALT_ADDR));
endmodule

// File: rtl/ucode_ctrl_unit.sv
// Top of the microprogrammed control sequencer.
// Ties the opcode map, the microcode store and the sequencer together.
// Assumes the opcode input carries the memory buffer high byte during the
// decode word, and that the datapath acts on ctrl_o at the next clock edge.
// The control word is forced to zero while halted.
module ucode_ctrl_unit
    import ucu_pkg::*;
#(
    parameter int OP_W        = 8,
    parameter int CAR_W       = 8,
    parameter int SHIFT       = 3,
    parameter int HALT_OPCODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode_i,
    input  logic             flag_i,
    output logic [CW_W-1:0]  ctrl_o,
    output logic [CAR_W-1:0] car_o,
    output logic             halted_o
);
    localparam logic [CAR_W-1:0] HALT_ADDR = CAR_W'(HALT_OPCODE << SHIFT);

    logic [CAR_W-1:0] map_addr;
    logic [CAR_W-1:0] car;
    cword_t           word;
    logic             halted;

    ucu_opcode_map #(.OP_W(OP_W), .CAR_W(CAR_W), .SHIFT(SHIFT)) u_map (
        .opcode_i (opcode_i),
        .start_o  (map_addr)
    );

    ucu_ctrl_store #(.CAR_W(CAR_W)) u_store (
        .addr_i (car),
        .word_o (word)
    );

    ucu_sequencer #(.CAR_W(CAR_W), .HALT_ADDR(HALT_ADDR)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (word),
        .map_addr_i (map_addr),
        .flag_i     (flag_i),
        .car_o      (car),
        .halted_o   (halted)
    );

    // Drive the enables, silenced once halted
    always_comb ctrl_o   = halted ? '0 : word;
    always_comb car_o    = car;
    always_comb halted_o = halted;

    p_fetch_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && car == '0) |-> (ctrl_o == W_FETCH_MAR));
endmodule

// File: tb/tb_ucode_ctrl_unit.sv
module tb_ucode_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        flag = 1'b0;
    logic [21:0] ctrl;
    logic [7:0]  car;
    logic        halted;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ucode_ctrl_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode),
        .flag_i   (flag),
        .ctrl_o   (ctrl),
        .car_o    (car),
        .halted_o (halted)
    );

    always #5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Check address and word now, then advance one cycle
    task automatic step(input logic [7:0] ecar, input logic [21:0] eword, input string req);
        chk(32'(car), 32'(ecar), {req, " addr"});
        chk(32'(ctrl), 32'(eword), {req, " word"});
        chk(32'(halted), 0, {req, " halted"});
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(32'(car), 0, "R1 reset addr");
        chk(32'(halted), 0, "R1 reset halted");
        chk(32'(ctrl), 32'h21, "R1 reset word");
    endtask

    task automatic fetch(input logic [7:0] op);
        opcode = op;
        step(8'h00, 22'h000021, "R7 fetch0 R2 R3");
        step(8'h01, 22'h000009, "R7 fetch1");
        step(8'h02, 22'h000082, "R7 decode R4");
    endtask

    task automatic t_store;
        fetch(8'h01);
        step(8'h08, 22'h000141, "R8 R10 store");
        step(8'h09, 22'h001001, "R10 store");
        step(8'h0A, 22'h000014, "R10 store R5");
        chk(32'(car), 0, "R5 store return");
    endtask

    task automatic t_load;
        fetch(8'h02);
        step(8'h10, 22'h000141, "R8 R9 load");
        step(8'h11, 22'h000009, "R9 load");
        step(8'h12, 22'h000601, "R9 load");
        step(8'h13, 22'h104001, "R9 load");
        step(8'h14, 22'h008001, "R9 load");
        step(8'h15, 22'h002004, "R9 load");
        chk(32'(car), 0, "R5 load return");
    endtask

    task automatic t_add;
        fetch(8'h03);
        step(8'h18, 22'h000141, "R8 R9 add");
        step(8'h19, 22'h000009, "R9 add");
        step(8'h1A, 22'h000201, "R9 add");
        step(8'h1B, 22'h104001, "R9 add");
        step(8'h1C, 22'h008001, "R9 add");
        step(8'h1D, 22'h002004, "R9 add");
        chk(32'(car), 0, "R5 add return");
    endtask

    task automatic t_jmpgez(input logic f);
        flag = f;
        fetch(8'h04);
        step(8'h20, 22'h200000, "R8 R11 cond jump");
        if (!f) step(8'h21, 22'h080004, "R6 R11 taken");
        else    step(8'h22, 22'h000104, "R6 R11 not taken");
        chk(32'(car), 0, "R5 cond return");
        flag = 1'b0;
    endtask

    task automatic t_jmp;
        fetch(8'h05);
        step(8'h28, 22'h080004, "R8 R11 jump");
        chk(32'(car), 0, "R5 jump return");
    endtask

    task automatic t_mpy;
        fetch(8'h07);
        step(8'h38, 22'h000141, "R8 R9 mpy");
        step(8'h39, 22'h000009, "R9 mpy");
        step(8'h3A, 22'h000201, "R9 mpy");
        step(8'h3B, 22'h104001, "R9 mpy");
        step(8'h3C, 22'h010001, "R9 mpy");
        step(8'h3D, 22'h022004, "R9 mpy");
        chk(32'(car), 0, "R5 mpy return");
    endtask

    task automatic t_store_mr;
        fetch(8'h08);
        step(8'h40, 22'h000141, "R8 R10 store mr");
        step(8'h41, 22'h040001, "R10 store mr");
        step(8'h42, 22'h000014, "R10 store mr");
        chk(32'(car), 0, "R5 store mr return");
    endtask

    task automatic t_unassigned;
        fetch(8'h09);
        step(8'h48, 22'h000004, "R13 unassigned");
        chk(32'(car), 0, "R13 back to fetch");
    endtask

    task automatic t_wrap;
        fetch(8'h20);
        chk(32'(car), 0, "R4 opcode 0x20 wraps");
        chk(32'(ctrl), 32'h21, "R4 wrap word");
    endtask

    task automatic t_halt;
        fetch(8'h06);
        chk(32'(car), 32'h30, "R8 R12 halt addr");
        chk(32'(ctrl), 32'h4, "R12 halt word");
        @(negedge clk);
        chk(32'(halted), 1, "R12 halted");
        chk(32'(car), 32'h30, "R12 addr held");
        chk(32'(ctrl), 0, "R12 word quiet");
        opcode = 8'h02;
        flag = 1'b1;
        repeat (5) @(negedge clk);
        chk(32'(halted), 1, "R12 still halted");
        chk(32'(car), 32'h30, "R12 addr still held");
        chk(32'(ctrl), 0, "R12 word still quiet");
        flag = 1'b0;
        do_reset();
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_store();
        t_load();
        t_add();
        t_jmpgez(1'b0);
        t_jmpgez(1'b1);
        t_jmp();
        t_mpy();
        t_store_mr();
        t_unassigned();
        t_wrap();
        t_halt();
        t_load();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule